// File: doc/BRIEF.md
# Timer Tick Source Selector

This block decides what makes a timer count. It turns one of several candidate sources into a count-enable pulse, `tick_o`, that is one core-clock cycle wide. A small up/down counter driven by that pulse shows the result at `count_o`.

The candidate sources are:
- the core clock itself;
- the rising edge of one of four trigger lines from neighbouring timers, which lets one timer act as the prescaler of another;
- the edges of two asynchronous capture pins;
- an asynchronous external trigger pin.

Each asynchronous pin passes through a two-flop synchronizer. It then passes through a programmable consecutive-sample filter before edge detection.

Software-style controls choose the source:
- a 3-bit slave-mode field;
- a 3-bit trigger-select code;
- an edge polarity bit;
- a direct external-clock enable;
- a counter enable, a direction bit and an update strobe.

Top module: `tmr_clk_sel`

## Requirements
- R1: After reset, `count_o` is 0 and `tick_o` is 0.
- R2: With slave mode 000 and the direct external enable low, `tick_o` is high and the counter advances on every clock cycle in which `cnt_en_i` is 1. With `cnt_en_i` at 0, no source in any mode produces a tick.
- R3: The counter changes only on a tick or an update strobe. Counting up, it wraps from `reload_i` to 0. Counting down (`dir_down_i`=1), it wraps from 0 to `reload_i`.
- R4: In each cycle in which `upd_gen_i` is 1, the following clock edge loads 0 when counting up, or `reload_i` when counting down. This load takes priority over a tick in that same cycle.
- R5: With slave mode 111 and trigger-select 0xx, only a rising edge of `int_trig_i[sel[1:0]]` gives a tick. It gives exactly one tick, in the cycle right after the edge. A held level and unselected lines give none.
- R6: Trigger-select 100 ticks once on each edge, rising or falling, of filtered capture input A. `edge_pol_i` has no effect in this setting.
- R7: Trigger-select 101 uses filtered capture input A, and 110 uses filtered capture input B. `edge_pol_i`=0 counts rising edges and `edge_pol_i`=1 counts falling edges. The opposite edge and the unselected input give no tick.
- R8: Trigger-select 111 (with slave mode 111) ticks once on each rising edge of the filtered external trigger.
- R9: With `ext_direct_en_i`=1, only rising edges of the filtered external trigger give ticks. This holds whatever the slave mode is, including 000 and 111, and whatever the trigger-select code is.
- R10: With slave mode neither 000 nor 111, and the direct enable low, no tick is produced.
- R11: A filter setting of 0 passes each synchronized sample. A setting of N>0 changes the filtered level only after N+1 consecutive synchronized samples that differ from it. A pulse of N cycles or fewer is therefore dropped.
- R12: With a filter setting of N, a pin change made between two clock edges raises `tick_o` after the (4+N)-th following rising edge, for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| int_trig_i | input | 4 | Trigger lines from neighbouring timers (synchronous to clk_i) |
| cap_a_i | input | 1 | Asynchronous capture pin A |
| cap_b_i | input | 1 | Asynchronous capture pin B |
| ext_trig_i | input | 1 | Asynchronous external trigger pin |
| flt_a_cfg_i | input | FLT_W | Filter setting for capture pin A |
| flt_b_cfg_i | input | FLT_W | Filter setting for capture pin B |
| flt_ext_cfg_i | input | FLT_W | Filter setting for the external trigger |
| slave_mode_i | input | 3 | 000 internal clock, 111 external edge clock, others idle |
| trig_sel_i | input | 3 | Trigger-source code used in slave mode 111 |
| edge_pol_i | input | 1 | 0 rising, 1 falling edge for capture-pin clocks |
| ext_direct_en_i | input | 1 | External trigger clocks the counter directly |
| cnt_en_i | input | 1 | Counter enable |
| dir_down_i | input | 1 | 1 counts down |
| upd_gen_i | input | 1 | Update strobe: reinitialise the counter |
| reload_i | input | CNT_W | Auto-reload value |
| tick_o | output | 1 | One-cycle count-enable pulse |
| count_o | output | CNT_W | Counter value |

## Verification
Assertions check four rules on every cycle:
- a disabled counter yields no tick;
- the internal-clock mode ticks each enabled cycle and the idle slave modes never tick;
- the counter moves only with a tick or an update strobe;
- the strobe loads the correct value for the direction.

Only directed scenarios can show the rest:
- which edge each trigger code and polarity selects;
- the exact pin-to-tick latency;
- that filters drop short pulses;
- that the direct external path overrides the slave mode;
- the wrap values.

// File: rtl/tmr_clk_sel.sv
module tmr_clk_sel #(
  parameter int CNT_W = 16,
  parameter int FLT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [3:0]       int_trig_i,
  input  logic             cap_a_i,
  input  logic             cap_b_i,
  input  logic             ext_trig_i,
  input  logic [FLT_W-1:0] flt_a_cfg_i,
  input  logic [FLT_W-1:0] flt_b_cfg_i,
  input  logic [FLT_W-1:0] flt_ext_cfg_i,
  input  logic [2:0]       slave_mode_i,
  input  logic [2:0]       trig_sel_i,
  input  logic             edge_pol_i,
  input  logic             ext_direct_en_i,
  input  logic             cnt_en_i,
  input  logic             dir_down_i,
  input  logic             upd_gen_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic             tick_o,
  output logic [CNT_W-1:0] count_o
);
  localparam int NCH = 3;
  localparam int CH_A = 0;
  localparam int CH_B = 1;
  localparam int CH_X = 2;
  localparam logic [2:0] MODE_INT = 3'b000;
  localparam logic [2:0] MODE_EDGE = 3'b111;
  localparam logic [2:0] SEL_A_BOTH = 3'b100;
  localparam logic [2:0] SEL_A = 3'b101;
  localparam logic [2:0] SEL_B = 3'b110;
  localparam logic [2:0] SEL_X = 3'b111;

  logic [NCH-1:0]       pin_raw;
  logic [NCH*FLT_W-1:0] pin_cfg;
  logic [NCH-1:0]       filt, filt_d, rise, fall;
  logic [3:0]           trig_d, trig_rise;
  logic                 src, tick_c, tick_q;
  logic [CNT_W-1:0]     count_q;

  assign pin_raw = {ext_trig_i, cap_b_i, cap_a_i};
  assign pin_cfg = {flt_ext_cfg_i, flt_b_cfg_i, flt_a_cfg_i};

  for (genvar g = 0; g < NCH; g++) begin : g_pin
    logic             s1, s2, lvl, lvl_d;
    logic [FLT_W-1:0] run;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1 <= 1'b0;
        s2 <= 1'b0;
        lvl <= 1'b0;
        lvl_d <= 1'b0;
        run <= '0;
      end else begin
        s1 <= pin_raw[g];
        s2 <= s1;
        lvl_d <= lvl;
        if (s2 == lvl) begin
          run <= '0;
        end else if (run == pin_cfg[g*FLT_W +: FLT_W]) begin
          lvl <= s2;
          run <= '0;
        end else begin
          run <= run + 1'b1;
        end
      end
    end
    assign filt[g] = lvl;
    assign filt_d[g] = lvl_d;
  end

  assign rise = filt & ~filt_d;
  assign fall = ~filt & filt_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) trig_d <= '0;
    else         trig_d <= int_trig_i;
  end
  assign trig_rise = int_trig_i & ~trig_d;

  always_comb begin
    src = 1'b0;
    if (ext_direct_en_i) begin
      src = rise[CH_X];
    end else if (slave_mode_i == MODE_INT) begin
      src = 1'b1;
    end else if (slave_mode_i == MODE_EDGE) begin
      case (trig_sel_i)
        SEL_A_BOTH: src = rise[CH_A] | fall[CH_A];
        SEL_A:      src = edge_pol_i ? fall[CH_A] : rise[CH_A];
        SEL_B:      src = edge_pol_i ? fall[CH_B] : rise[CH_B];
        SEL_X:      src = rise[CH_X];
        default:    src = trig_rise[trig_sel_i[1:0]];
      endcase
    end
  end

  assign tick_c = cnt_en_i & src;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tick_q <= 1'b0;
      count_q <= '0;
    end else begin
      tick_q <= tick_c;
      if (upd_gen_i) begin
        count_q <= dir_down_i ? reload_i : '0;
      end else if (tick_c) begin
        if (dir_down_i) count_q <= (count_q == '0) ? reload_i : count_q - 1'b1;
        else            count_q <= (count_q >= reload_i) ? '0 : count_q + 1'b1;
      end
    end
  end

  assign tick_o = tick_q;
  assign count_o = count_q;

  a_r2_no_tick_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cnt_en_i |=> !tick_o);
  a_r2_internal_every_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_en_i && !ext_direct_en_i && slave_mode_i == MODE_INT) |=> tick_o);
  a_r10_idle_modes_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ext_direct_en_i && slave_mode_i != MODE_INT && slave_mode_i != MODE_EDGE) |=> !tick_o);
  a_r3_moves_only_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_o != $past(count_o)) |-> (tick_o || $past(upd_gen_i)));
  a_r4_update_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_gen_i && !dir_down_i) |=> count_o == '0);
  a_r4_update_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_gen_i && dir_down_i) |=> count_o == $past(reload_i));
endmodule

// File: tb/tmr_clk_sel_tb.sv
module tmr_clk_sel_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 16;
  localparam int FLT_W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] itrig = '0;
  logic cap_a = 1'b0, cap_b = 1'b0, ext = 1'b0;
  logic [FLT_W-1:0] fa = '0, fb = '0, fx = '0;
  logic [2:0] smode = 3'b000, tsel = 3'b000;
  logic pol = 1'b0, xdir = 1'b0, en = 1'b0, down = 1'b0, ug = 1'b0;
  logic [CNT_W-1:0] reload = 16'd100;
  logic tick;
  logic [CNT_W-1:0] count;

  int checks = 0;
  int errors = 0;
  int ticks = 0;
  int base;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr_clk_sel #(.CNT_W(CNT_W), .FLT_W(FLT_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .int_trig_i(itrig),
    .cap_a_i(cap_a), .cap_b_i(cap_b), .ext_trig_i(ext),
    .flt_a_cfg_i(fa), .flt_b_cfg_i(fb), .flt_ext_cfg_i(fx),
    .slave_mode_i(smode), .trig_sel_i(tsel), .edge_pol_i(pol),
    .ext_direct_en_i(xdir), .cnt_en_i(en), .dir_down_i(down),
    .upd_gen_i(ug), .reload_i(reload), .tick_o(tick), .count_o(count)
  );

  always @(posedge clk) begin
    #2;
    if (rst_n && tick) ticks++;
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_mode(logic [2:0] m, logic [2:0] s, logic p, logic x);
    @(negedge clk);
    en = 1'b0;
    smode = m; tsel = s; pol = p; xdir = x;
    wait_n(2);
    en = 1'b1;
    base = ticks;
  endtask

  task automatic pulse(ref logic sig, input int width);
    @(negedge clk);
    sig = 1'b1;
    wait_n(width);
    sig = 1'b0;
    wait_n(12);
  endtask

  task automatic t_reset;
    check("R1 count after reset", count, 0);
    check("R1 tick after reset", tick, 0);
  endtask

  task automatic t_internal;
    @(negedge clk);
    down = 1'b0; ug = 1'b1;
    @(negedge clk);
    ug = 1'b0;
    set_mode(3'b000, 3'b000, 1'b0, 1'b0);
    base = ticks;
    wait_n(10);
    en = 1'b0;
    check("R2 count after 10 enabled cycles", count, 10);
    check("R2 ticks after 10 enabled cycles", ticks - base, 10);
    wait_n(5);
    check("R2 count frozen while disabled", count, 10);
  endtask

  task automatic t_wrap;
    @(negedge clk);
    en = 1'b0; reload = 16'd5; down = 1'b0; ug = 1'b1;
    @(negedge clk);
    ug = 1'b0;
    en = 1'b1;
    wait_n(7);
    en = 1'b0;
    check("R3 up wrap at reload", count, 1);
    down = 1'b1; ug = 1'b1;
    @(negedge clk);
    ug = 1'b0;
    check("R4 update down loads reload", count, 5);
    en = 1'b1;
    wait_n(7);
    en = 1'b0;
    check("R3 down wrap at zero", count, 4);
  endtask

  task automatic t_update_priority;
    @(negedge clk);
    down = 1'b0; en = 1'b1;
    wait_n(2);
    ug = 1'b1;
    @(negedge clk);
    ug = 1'b0;
    check("R4 update beats tick", count, 0);
    @(negedge clk);
    check("R4 count resumes", count, 1);
    en = 1'b0;
    reload = 16'd100;
  endtask

  task automatic t_int_trig;
    set_mode(3'b111, 3'b010, 1'b0, 1'b0);
    itrig[2] = 1'b1;
    @(negedge clk);
    check("R5 tick right after trigger edge", tick, 1);
    @(negedge clk);
    check("R5 tick one cycle wide", tick, 0);
    wait_n(5);
    itrig[2] = 1'b0;
    itrig[1] = 1'b1;
    wait_n(4);
    itrig[1] = 1'b0;
    wait_n(2);
    check("R5 one tick for held level, none unselected", ticks - base, 1);
  endtask

  task automatic t_both_edges;
    set_mode(3'b111, 3'b100, 1'b1, 1'b0);
    pulse(cap_a, 6);
    check("R6 both edges of A counted", ticks - base, 2);
  endtask

  task automatic t_polarity;
    set_mode(3'b111, 3'b101, 1'b0, 1'b0);
    pulse(cap_a, 6);
    check("R7 A rising polarity", ticks - base, 1);
    set_mode(3'b111, 3'b101, 1'b1, 1'b0);
    @(negedge clk);
    cap_a = 1'b1;
    wait_n(12);
    check("R7 A falling polarity ignores rise", ticks - base, 0);
    cap_a = 1'b0;
    wait_n(12);
    check("R7 A falling polarity counts fall", ticks - base, 1);
    set_mode(3'b111, 3'b110, 1'b0, 1'b0);
    pulse(cap_a, 6);
    check("R7 B selected ignores A", ticks - base, 0);
    pulse(cap_b, 6);
    check("R7 B rising counted", ticks - base, 1);
  endtask

  task automatic t_ext;
    set_mode(3'b111, 3'b111, 1'b0, 1'b0);
    pulse(ext, 6);
    pulse(ext, 6);
    check("R8 external trigger rising edges", ticks - base, 2);
  endtask

  task automatic t_direct;
    set_mode(3'b111, 3'b101, 1'b0, 1'b1);
    pulse(cap_a, 6);
    check("R9 direct mode ignores selected A", ticks - base, 0);
    pulse(ext, 6);
    check("R9 direct mode counts external", ticks - base, 1);
    set_mode(3'b000, 3'b000, 1'b0, 1'b1);
    wait_n(10);
    check("R9 direct mode overrides internal clock", ticks - base, 0);
  endtask

  task automatic t_idle_mode;
    set_mode(3'b100, 3'b101, 1'b0, 1'b0);
    pulse(cap_a, 6);
    itrig[0] = 1'b1;
    wait_n(3);
    itrig[0] = 1'b0;
    wait_n(8);
    check("R10 idle slave mode gives no ticks", ticks - base, 0);
  endtask

  task automatic t_filter;
    fa = 4'd3;
    set_mode(3'b111, 3'b101, 1'b0, 1'b0);
    pulse(cap_a, 3);
    check("R11 pulse of N cycles dropped", ticks - base, 0);
    pulse(cap_a, 4);
    check("R11 pulse of N+1 cycles passes", ticks - base, 1);
    fa = 4'd0;
  endtask

  task automatic t_latency;
    set_mode(3'b111, 3'b101, 1'b0, 1'b0);
    @(negedge clk);
    cap_a = 1'b1;
    wait_n(3);
    check("R12 no tick before 4th edge", tick, 0);
    @(negedge clk);
    check("R12 tick after 4th edge", tick, 1);
    @(negedge clk);
    check("R12 tick lasts one cycle", tick, 0);
    cap_a = 1'b0;
    fa = 4'd2;
    wait_n(12);
    cap_a = 1'b1;
    wait_n(5);
    check("R12 filtered: no tick before 6th edge", tick, 0);
    @(negedge clk);
    check("R12 filtered: tick after 6th edge", tick, 1);
    cap_a = 1'b0;
    fa = 4'd0;
    wait_n(12);
  endtask

  initial begin
    wait_n(3);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_internal();
    t_wrap();
    t_update_priority();
    t_int_trig();
    t_both_edges();
    t_polarity();
    t_ext();
    t_direct();
    t_idle_mode();
    t_filter();
    t_latency();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule